// File: doc/BRIEF.md
# Fractional reference clock divider

This block produces a reference clock output from one of up to sixteen source signals. The chosen source is divided by twice a value made of a 15-bit integer part N and a 9-bit fraction M counted in 512ths, so the output frequency is f_src / (2·(N + M/512)). The fraction comes from dithering: a 9-bit accumulator adds M at the end of every half-period. When the addition carries, the next half-period is one source cycle longer. When N is zero the divider is bypassed and the chosen source goes straight to the output.

Software uses two 32-bit registers. The control register holds the source select, the enables and the integer part. The trim register holds the fraction. Written values of N and M sit in shadow fields until a divider-switch request copies them into the running divider. The block clears the request bit once the copy is done. While the generator is active the source select is frozen. The source signals are sampled in the block's own clock domain. One source cycle is counted per rising edge of the chosen, sampled source.

Top module: `refclk_gen`

## Requirements
- R1: After reset both registers read 0 and clk_out is 0.
- R2: Control bit 8 (active) rises one clock after bit 15 (on) is set. After on is cleared, active falls at the end of the current half-period, or one clock later when N is 0.
- R3: clk_out is 0 unless on (bit 15) and output enable (bit 12) are both set.
- R4: With a working N of 0, clk_out follows the selected source one clock later.
- R5: With M equal to 0 and N not 0, each half-period of clk_out lasts exactly N source cycles.
- R6: With N not 0, each half-period lasts N or N+1 source cycles. Counting from the first output edge after start, 512 consecutive half-periods total 512·N + M source cycles.
- R7: Control bits 30:16 (N) and trim bits 31:23 (M) take effect only after a 1 is written to control bit 9 (divider switch). Bit 9 reads 1 until the copy is done. When idle the copy happens on the next clock. When running it happens at the next half-period end.
- R8: Control bits 3:0 select the source. Writes to that field are ignored while active is 1.
- R9: Register address 0 is control and address 1 is trim. In control, bits 31, 14:13, 11:10 and 7:4 read 0. In trim, only bits 31:23 are stored, and all other bits read 0.
- R10: Activity on sources that are not selected has no effect on clk_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Candidate source signals |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 trim |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 trim |
| rd_data | output | 32 | Read data for rd_addr |
| clk_out | output | 1 | Divided reference clock output |

## Verification
Two events can fall in the same clock while the generator runs: a pending divider-switch request and the end of a half-period. The bench provokes this by requesting a new integer part from 5 to 3 while the output is toggling. The copy must then land on a half-period boundary. The bench judges it by the request bit clearing and by every later half-period measuring the new length exactly. Turning the generator off also meets a half-period end. The bench checks that active drops within one half-period of the request.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int REG_W      = 32;
  localparam int INT_W      = 15;
  localparam int FRAC_W     = 9;
  localparam bit ADDR_CTRL  = 1'b0;
  localparam bit ADDR_TRIM  = 1'b1;
  localparam int SEL_LSB    = 0;
  localparam int ACT_BIT    = 8;
  localparam int SWITCH_BIT = 9;
  localparam int OE_BIT     = 12;
  localparam int ON_BIT     = 15;
  localparam int INT_LSB    = 16;
  localparam int FRAC_LSB   = 23;
endpackage

// File: rtl/refclk_regs.sv
module refclk_regs
  import refclk_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_addr,
  input  logic              active,
  input  logic              load_done,
  output logic [SEL_W-1:0]  sel,
  output logic              on,
  output logic              oe,
  output logic              sw_req,
  output logic [INT_W-1:0]  int_sh,
  output logic [FRAC_W-1:0] frac_sh,
  output logic [REG_W-1:0]  rd_data
);
  logic              ctrl_wr, trim_wr;
  logic [SEL_W-1:0]  sel_d;
  logic              on_d, oe_d, sw_d;
  logic [INT_W-1:0]  int_d;
  logic [FRAC_W-1:0] frac_d;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign trim_wr = wr_en && (wr_addr == ADDR_TRIM);

  always_comb begin
    sel_d  = sel;
    on_d   = on;
    oe_d   = oe;
    int_d  = int_sh;
    frac_d = frac_sh;
    sw_d   = sw_req & ~load_done;
    if (ctrl_wr) begin
      if (!active) sel_d = wr_data[SEL_LSB +: SEL_W];
      on_d  = wr_data[ON_BIT];
      oe_d  = wr_data[OE_BIT];
      int_d = wr_data[INT_LSB +: INT_W];
      if (wr_data[SWITCH_BIT]) sw_d = 1'b1;
    end
    if (trim_wr) frac_d = wr_data[FRAC_LSB +: FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      on      <= 1'b0;
      oe      <= 1'b0;
      sw_req  <= 1'b0;
      int_sh  <= '0;
      frac_sh <= '0;
    end else begin
      sel     <= sel_d;
      on      <= on_d;
      oe      <= oe_d;
      sw_req  <= sw_d;
      int_sh  <= int_d;
      frac_sh <= frac_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) begin
      rd_data[SEL_LSB +: SEL_W] = sel;
      rd_data[ACT_BIT]          = active;
      rd_data[SWITCH_BIT]       = sw_req;
      rd_data[OE_BIT]           = oe;
      rd_data[ON_BIT]           = on;
      rd_data[INT_LSB +: INT_W] = int_sh;
    end else begin
      rd_data[FRAC_LSB +: FRAC_W] = frac_sh;
    end
  end
endmodule

// File: rtl/refclk_srcsel.sv
module refclk_srcsel #(
  parameter int NSRC  = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic [SEL_W-1:0] sel,
  output logic             level,
  output logic             tick
);
  logic [NSRC-1:0] src_q;
  logic            prev_q;

  assign level = src_q[sel];
  assign tick  = level & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      src_q  <= src_in;
      prev_q <= level;
    end
  end
endmodule

// File: rtl/refclk_fracdiv.sv
module refclk_fracdiv #(
  parameter int INT_W  = 15,
  parameter int FRAC_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              on,
  input  logic              sw_req,
  input  logic [INT_W-1:0]  int_sh,
  input  logic [FRAC_W-1:0] frac_sh,
  output logic              active,
  output logic              load_done,
  output logic              bypass,
  output logic              div_out
);
  localparam int H_W = INT_W + 1;

  logic              act_d, div_d;
  logic [INT_W-1:0]  n_q, n_d;
  logic [FRAC_W-1:0] m_q, m_d, acc_q, acc_d, acc_sum;
  logic [H_W-1:0]    cnt_q, cnt_d, hlen_q, hlen_d;
  logic              carry, half_end;

  assign bypass    = (n_q == '0);
  assign half_end  = active && !bypass && tick && (cnt_q == hlen_q - 1'b1);
  assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, m_q};
  assign load_done = sw_req && (!active || bypass || half_end);

  always_comb begin
    if (!active)     act_d = on;
    else if (on)     act_d = 1'b1;
    else if (bypass) act_d = 1'b0;
    else             act_d = !half_end;

    n_d    = load_done ? int_sh  : n_q;
    m_d    = load_done ? frac_sh : m_q;
    div_d  = div_out;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    hlen_d = hlen_q;

    if (!active || !act_d) begin
      div_d  = 1'b0;
      cnt_d  = '0;
      acc_d  = '0;
      hlen_d = {1'b0, n_d};
    end else if (load_done) begin
      div_d  = div_out ^ half_end;
      cnt_d  = '0;
      acc_d  = '0;
      hlen_d = {1'b0, int_sh};
    end else if (half_end) begin
      div_d  = ~div_out;
      cnt_d  = '0;
      acc_d  = acc_sum;
      hlen_d = {1'b0, n_q} + {{INT_W{1'b0}}, carry};
    end else if (tick) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_out <= 1'b0;
      n_q     <= '0;
      m_q     <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      hlen_q  <= '0;
    end else begin
      active  <= act_d;
      div_out <= div_d;
      n_q     <= n_d;
      m_q     <= m_d;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      hlen_q  <= hlen_d;
    end
  end
endmodule

// File: rtl/refclk_gen.sv
module refclk_gen
  import refclk_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_in,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             rd_addr,
  output logic [31:0]      rd_data,
  output logic             clk_out
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic              rst_meta, rst_q;
  logic [SEL_W-1:0]  sel;
  logic              on, oe, sw_req, active, load_done, bypass, div_out;
  logic              level, tick;
  logic [INT_W-1:0]  int_sh;
  logic [FRAC_W-1:0] frac_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  refclk_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .active(active),
    .load_done(load_done), .sel(sel), .on(on), .oe(oe), .sw_req(sw_req),
    .int_sh(int_sh), .frac_sh(frac_sh), .rd_data(rd_data)
  );

  refclk_srcsel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_src (
    .clk(clk), .rst_n(rst_q), .src_in(src_in), .sel(sel),
    .level(level), .tick(tick)
  );

  refclk_fracdiv #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_q), .tick(tick), .on(on), .sw_req(sw_req),
    .int_sh(int_sh), .frac_sh(frac_sh), .active(active),
    .load_done(load_done), .bypass(bypass), .div_out(div_out)
  );

  assign clk_out = on && oe && active && (bypass ? level : div_out);
endmodule

// File: rtl/refclk_gen_chk.sv
module refclk_gen_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             on,
  input logic             oe,
  input logic             active,
  input logic             sw_req,
  input logic [SEL_W-1:0] sel,
  input logic             clk_out,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [31:0]      wr_data
);
  // R2
  active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(on));
  // R2
  active_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !$past(on));
  // R3
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> (on && oe));
  // R7
  idle_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !active && !(wr_en && !wr_addr && wr_data[9])) |=> !sw_req);
  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(sel));
endmodule

bind refclk_gen refclk_gen_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .on(on), .oe(oe), .active(active),
  .sw_req(sw_req), .sel(sel), .clk_out(clk_out), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/refclk_gen_tb.sv
`timescale 1ns/1ps
module refclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_in = '0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        clk_out;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit wave_en = 0, noise = 0, chk_byp = 0, done = 0;
  int wave_bit = 0;

  refclk_gen u_dut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_out(clk_out));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(input int sel, input int n, input bit on,
                                       input bit oe, input bit sw);
    return (32'(n) << 16) | (32'(on) << 15) | (32'(oe) << 12) | (32'(sw) << 9) | 32'(sel & 15);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // source driver; bypass follow-check samples before redriving
  always @(negedge clk) begin
    logic [15:0] nx;
    if (chk_byp) chk(clk_out == src_in[wave_bit], "R4/R10 bypass follow", clk_out, src_in[wave_bit]);
    nx = src_in;
    if (noise) for (int b = 0; b < 16; b++) if (b != wave_bit) nx[b] = 1'($urandom);
    if (wave_en) nx[wave_bit] = ~nx[wave_bit];
    src_in = nx;
  end

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input bit a, output logic [31:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic wait_idle(input int bound, input string req);
    logic [31:0] v;
    int k = 0;
    rd(0, v);
    while (v[8] && k < bound) begin @(negedge clk); rd(0, v); k++; end
    chk(!v[8], req, k, bound);
  endtask

  // measure half-periods in clock cycles (one source cycle = 2 clocks)
  task automatic measure(input int halves, input int n, input int m, input string req);
    logic prev = clk_out;
    int cyc = 0, total = 0;
    while (clk_out == prev && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(cyc < 4000, {req, " first edge"}, cyc, 0);
    prev = clk_out;
    for (int i = 0; i < halves; i++) begin
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (clk_out == prev && cyc < 4000);
      prev = clk_out;
      total += cyc;
      if (m == 0) chk(cyc == 2*n, req, cyc, 2*n);
      else chk(cyc == 2*n || cyc == 2*n + 2, req, cyc, 2*n);
    end
    if (halves == 512) chk(total == 2*(512*n + m), "R6 512-half total", total, 2*(512*n + m));
  endtask

  task automatic frac_round(input int sel, input int n, input int m);
    wait_idle(4*n + 20, "R2 off");
    wave_bit = sel; wave_en = 1; noise = 1;
    wr(1, 32'(m) << 23);
    wr(0, ctrl(sel, n, 0, 0, 1));
    @(negedge clk);
    wr(0, ctrl(sel, n, 1, 1, 0));
    measure(512, n, m, "R6 half length");
    wr(0, ctrl(sel, n, 0, 1, 0));
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1
    rd(0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(1, v); chk(v == 0, "R1 trim reset", v, 0);
    chk(clk_out == 0, "R1 clk_out reset", clk_out, 0);
    // R9 layout
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk(v == 32'hFF80_0000, "R9 trim", v, 32'hFF80_0000);
    wr(0, 32'hFFFF_7DFF); rd(0, v); chk(v == 32'h7FFF_100F, "R9 ctrl", v, 32'h7FFF_100F);
    wr(1, 0);
    // R2 rise, R4 bypass (shadow N unused, R7), R10 noise
    wave_bit = 15; wave_en = 1; noise = 1;
    wr(0, ctrl(15, 16'h7FFF, 1, 1, 0));
    rd(0, v); chk(!v[8], "R2 active one cycle late", v[8], 0);
    @(negedge clk); rd(0, v); chk(v[8], "R2 active rise", v[8], 1);
    chk_byp = 1;
    repeat (40) @(negedge clk);
    chk_byp = 0;
    // R3 oe low
    wr(0, ctrl(15, 16'h7FFF, 1, 0, 0));
    for (int i = 0; i < 20; i++) begin @(negedge clk); chk(clk_out == 0, "R3 oe low", clk_out, 0); end
    // R2 bypass turn-off
    wr(0, ctrl(15, 16'h7FFF, 0, 1, 0));
    rd(0, v); chk(v[8], "R2 bypass active still", v[8], 1);
    @(negedge clk); rd(0, v); chk(!v[8], "R2 bypass fall", v[8], 0);
    for (int i = 0; i < 10; i++) begin @(negedge clk); chk(clk_out == 0, "R3 on low", clk_out, 0); end
    // R7 idle switch timing
    wave_bit = 2;
    wr(0, ctrl(2, 5, 0, 0, 1));
    rd(0, v); chk(v[9], "R7 switch pending", v[9], 1);
    @(negedge clk); rd(0, v); chk(!v[9], "R7 switch done", v[9], 0);
    chk(v[3:0] == 2, "R8 sel when idle", v[3:0], 2);
    // R5 integer divide with noise on other sources (R10)
    wr(0, ctrl(2, 5, 1, 1, 0));
    measure(20, 5, 0, "R5/R10 integer half");
    // R8 sel frozen while active
    wr(0, ctrl(5, 5, 1, 1, 0));
    rd(0, v); chk(v[3:0] == 2, "R8 sel frozen", v[3:0], 2);
    // R7 running switch lands on a half-period end
    wr(0, ctrl(2, 3, 1, 1, 1));
    repeat (30) @(negedge clk);
    rd(0, v); chk(!v[9], "R7 running switch done", v[9], 0);
    measure(12, 3, 0, "R7 new N after switch");
    wr(0, ctrl(2, 3, 0, 1, 0));
    // R6 fractional rounds: corners then random
    frac_round(2, 1, 511);
    frac_round(7, 2, 1);
    for (int r = 0; r < 3; r++) frac_round(int'($urandom_range(15, 0)),
                                           int'($urandom_range(4, 1)),
                                           int'($urandom_range(511, 0)));
    wait_idle(40, "R2 final off");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule